// File: doc/BRIEF.md
# Sequence-Tagged Cross-Clock Transfer Bridge

The bridge carries one memory-style transfer at a time from a requester clock domain to a responder clock domain and brings the result back. The two clocks have no phase or frequency relation. Each transfer is marked by a 2-bit Gray-coded sequence tag. The requester advances the tag when it accepts a command. The responder returns the tag once the result is ready. A transfer is finished when the returned tag equals the tag that was sent. No return-to-idle phase is needed, so the next command can be accepted on the same edge that completes the previous one.

Only the tags pass through two-flop synchronisers. The command payload (operation, address, write data) is held in requester registers from the tag change until the echo arrives. The response word is held in responder registers from just before the echo until the next request. Each side therefore reads the other side's bundle only while that bundle is stable. The responder model is a small word-addressed store with a fixed access latency. It supports load, store and swap.

Top module: `tagged_xfer_bridge`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0, `rdata` is 0, and every word of the responder store reads as 0.
- R2: Operation codes on `cmd_op`: 2'b01 load returns the stored word. 2'b10 store writes `cmd_wdata` and returns it. 2'b11 swap writes `cmd_wdata` and returns the word that was there before.
- R3: A command with `cmd_op` = 2'b00 is never accepted. It produces no `done`, leaves `cmd_ready` high and leaves the store unchanged.
- R4: Only one transfer is outstanding. `cmd_ready` is low from the acceptance edge until the completing edge, and a command presented in that interval is not taken early.
- R5: Each accepted command produces exactly one `done` pulse, one requester cycle wide.
- R6: Completion happens when the synchronised echo equals the current tag. On that edge a waiting command is accepted, so `done` and the next acceptance coincide with no idle cycle between them.
- R7: The tag is 2-bit Gray code (00, 01, 11, 10, then 00 again). It advances by exactly one step, a single bit change, per accepted command and is otherwise unchanged.
- R8: Operation, address and write data presented to the responder stay stable for as long as the transfer is outstanding.
- R9: The responder updates its response word at least one responder cycle before it changes the echoed tag.
- R10: `rdata` holds the result of the last completed transfer until the next `done`.
- R11: The responder starts a transfer only when the synchronised tag differs from the last tag it serviced. An unchanged tag is never serviced again, and the echo never runs ahead of the requester's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_req | input | 1 | Requester-domain clock |
| rst_req_n | input | 1 | Requester-domain reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Bridge can take a command this cycle |
| cmd_op | input | 2 | Operation: 00 none, 01 load, 10 store, 11 swap |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write data for store and swap |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Result of the last completed transfer |
| clk_rsp | input | 1 | Responder-domain clock |
| rst_rsp_n | input | 1 | Responder-domain reset, active low |

## Verification
The assertions assume that both resets are applied together before any command is offered. They also assume that the command fields are meaningful whenever `cmd_valid` is high with a non-zero operation. The bench releases both resets in the same window. It changes command fields only at requester falling edges, and it drops `cmd_valid` or replaces the command only after an acceptance edge. Randomised operation, address and data sequences run with the two clocks at unrelated periods, so the synchronised tags reach the far side at varying phases.

// File: rtl/tsb_pkg.sv
`timescale 1ns/1ps
package tsb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_SWAP  = 2'b11
  } op_e;

  // Next value in the 2-bit Gray sequence 00,01,11,10
  function automatic logic [1:0] gray_step(input logic [1:0] g);
    logic [1:0] b;
    b = {g[1], g[1] ^ g[0]};
    b = b + 2'd1;
    return {b[1], b[1] ^ b[0]};
  endfunction

  function automatic logic op_writes(input op_e op);
    return (op == OP_STORE) || (op == OP_SWAP);
  endfunction

  function automatic logic op_returns_old(input op_e op);
    return (op == OP_LOAD) || (op == OP_SWAP);
  endfunction

endpackage

// File: rtl/tsb_sync.sv
`timescale 1ns/1ps
module tsb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tsb_requester.sv
`timescale 1ns/1ps
module tsb_requester
  import tsb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        req_tag,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        echo_sync,
  input  logic [DATA_W-1:0] rsp_data
);
  logic              busy_q;
  logic [1:0]        tag_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  // Named internal events
  logic complete;
  logic accept;

  assign complete  = busy_q && (echo_sync == tag_q);
  assign cmd_ready = !busy_q || complete;
  assign accept    = cmd_valid && cmd_ready && (cmd_op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tag_q   <= 2'b00;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= complete;
      if (complete) rdata_q <= rsp_data;
      if (accept) begin
        tag_q   <= gray_step(tag_q);
        op_q    <= op_e'(cmd_op);
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        busy_q  <= 1'b1;
      end else if (complete) begin
        busy_q  <= 1'b0;
      end
    end
  end

  assign done      = done_q;
  assign rdata     = rdata_q;
  assign req_tag   = tag_q;
  assign req_op    = op_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;

  // R7: one bit changes per advance
  assert_gray_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q != $past(tag_q)) |-> ($countones(tag_q ^ $past(tag_q)) == 1));

  // R7: tag moves only on acceptance
  assert_tag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tag_q));

  // R8: payload frozen while the transfer is in flight
  assert_payload_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !complete) |=> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q)));

  // R5: completion pulse is a single cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11: echo never runs ahead of the issued tag
  assert_echo_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (echo_sync != gray_step(tag_q)));
endmodule

// File: rtl/tsb_responder.sv
`timescale 1ns/1ps
module tsb_responder
  import tsb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_tag_sync,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [1:0]        rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = (LAT < 2) ? 1 : $clog2(LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WORK, S_POST} state_e;

  function automatic logic [DATA_W-1:0] result_of(input op_e op,
                                                  input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] wd);
    return op_returns_old(op) ? old : wd;
  endfunction

  state_e            st_q;
  logic [1:0]        seen_q;
  logic [1:0]        echo_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  // Named internal events
  logic new_req;
  logic access_now;

  assign new_req    = (st_q == S_IDLE) && (req_tag_sync != seen_q);
  assign access_now = (st_q == S_WORK) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      seen_q  <= 2'b00;
      echo_q  <= 2'b00;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (new_req) begin
            seen_q  <= req_tag_sync;
            op_q    <= op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cnt_q   <= CW'(LAT - 1);
            st_q    <= S_WORK;
          end
        end
        S_WORK: begin
          if (access_now) begin
            data_q <= result_of(op_q, mem_q[addr_q], wdata_q);
            if (op_writes(op_q)) mem_q[addr_q] <= wdata_q;
            st_q <= S_POST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_POST: begin
          echo_q <= seen_q;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_tag  = echo_q;
  assign rsp_data = data_q;

  // R9: response word settled before the echo moves
  assert_data_before_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_q != $past(echo_q)) |-> $stable(data_q));

  // R11: when idle, everything taken has been echoed
  assert_idle_echoed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> (echo_q == seen_q));

  // R4: a new request is only taken after the previous echo
  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |=> (st_q == S_WORK));

  // R11: serviced tag changes only by one Gray step
  assert_seen_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != $past(seen_q)) |-> (seen_q == gray_step($past(seen_q))));
endmodule

// File: rtl/tagged_xfer_bridge.sv
`timescale 1ns/1ps
module tagged_xfer_bridge #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int RSP_LAT = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_req,
  input  logic              rst_req_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              clk_rsp,
  input  logic              rst_rsp_n
);
  logic [1:0]        req_tag;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [1:0]        req_tag_sync;
  logic [1:0]        rsp_tag;
  logic [1:0]        echo_sync;
  logic [DATA_W-1:0] rsp_data;

  tsb_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk_req), .rst_n(rst_req_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .done(done), .rdata(rdata),
    .req_tag(req_tag), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .echo_sync(echo_sync), .rsp_data(rsp_data)
  );

  tsb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_fwd (
    .clk(clk_rsp), .rst_n(rst_rsp_n), .d(req_tag), .q(req_tag_sync)
  );

  tsb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_back (
    .clk(clk_req), .rst_n(rst_req_n), .d(rsp_tag), .q(echo_sync)
  );

  tsb_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(RSP_LAT)) u_rsp (
    .clk(clk_rsp), .rst_n(rst_rsp_n),
    .req_tag_sync(req_tag_sync), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );
endmodule

// File: tb/tagged_xfer_bridge_test.sv
`timescale 1ns/1ps
module tagged_xfer_bridge_test;
  logic clk_req = 1'b0;
  logic clk_rsp = 1'b0;
  logic rst_req_n = 1'b0;
  logic rst_rsp_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [3:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic done;
  logic [31:0] rdata;

  always #5 clk_req = ~clk_req;
  always #7 clk_rsp = ~clk_rsp;

  tagged_xfer_bridge uut (
    .clk_req(clk_req), .rst_req_n(rst_req_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .done(done), .rdata(rdata),
    .clk_rsp(clk_rsp), .rst_rsp_n(rst_rsp_n)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] model [16];

  function automatic logic [31:0] exp_result(input logic [1:0] op, input logic [31:0] old,
                                             input logic [31:0] wd);
    return (op == 2'b10) ? wd : old;   // store echoes write data; load/swap give old word
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (done !== 1'b1) begin
      @(negedge clk_req);
      cyc++;
    end
  endtask

  // One complete transfer with all per-transfer checks
  task automatic issue(input logic [1:0] op, input logic [3:0] a, input logic [31:0] wd);
    int cyc;
    logic [31:0] exp;
    @(negedge clk_req);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    while (cmd_ready !== 1'b1) @(negedge clk_req);
    @(negedge clk_req);
    cmd_valid = 1'b0;
    check("R4", "ready low after accept", {31'd0, cmd_ready}, 32'd0);
    wait_done(cyc);
    exp = exp_result(op, model[a], wd);
    if (op[1]) model[a] = wd;
    check("R2/R7", "result word", rdata, exp);
    @(negedge clk_req);
    check("R5", "done one cycle", {31'd0, done}, 32'd0);
    check("R10", "rdata held after done", rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_req);
    errors++;
    $display("FAIL R5 watchdog: actual=hung expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (4) @(posedge clk_rsp);
    @(negedge clk_req);
    rst_req_n = 1'b1; rst_rsp_n = 1'b1;
    @(negedge clk_req);
    // R1 reset state
    check("R1", "cmd_ready after reset", {31'd0, cmd_ready}, 32'd1);
    check("R1", "done after reset", {31'd0, done}, 32'd0);
    check("R1", "rdata after reset", rdata, 32'd0);
    issue(2'b01, 4'd0, 32'd0);    // R1: store reads zero
    issue(2'b01, 4'd15, 32'd0);   // R1

    // R2 directed ops
    issue(2'b10, 4'd3, 32'hDEAD_BEEF);
    issue(2'b01, 4'd3, 32'h0);
    issue(2'b11, 4'd3, 32'h1234_5678);
    issue(2'b01, 4'd3, 32'h0);

    // R3: idle op ignored
    @(negedge clk_req);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 4'd3; cmd_wdata = 32'hFFFF_FFFF;
    begin
      int bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk_req);
        if (done !== 1'b0 || cmd_ready !== 1'b1) bad++;
      end
      check("R3", "idle op raised done or dropped ready", bad, 0);
    end
    cmd_valid = 1'b0;
    issue(2'b01, 4'd3, 32'h0);    // R3: store untouched

    // R11: quiet period, no repeat service
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk_req);
        if (done) extra++;
      end
      check("R11", "done without new command", extra, 0);
    end

    // R6/R4: back-to-back with command held
    @(negedge clk_req);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 4'd5; cmd_wdata = 32'hA5A5_0001;
    while (cmd_ready !== 1'b1) @(negedge clk_req);
    @(negedge clk_req);
    cmd_op = 2'b11; cmd_addr = 4'd5; cmd_wdata = 32'h0BAD_F00D;
    check("R4", "busy while first outstanding", {31'd0, cmd_ready}, 32'd0);
    while (cmd_ready !== 1'b1) @(negedge clk_req);
    check("R4", "second not taken early", {31'd0, done}, 32'd0);
    @(negedge clk_req);
    cmd_valid = 1'b0;
    check("R6", "done with first result", {31'd0, done}, 32'd1);
    check("R6", "next accepted same edge", {31'd0, cmd_ready}, 32'd0);
    check("R6", "first result word", rdata, 32'hA5A5_0001);
    @(negedge clk_req);
    wait_done(cyc);
    check("R6", "second result word", rdata, 32'hA5A5_0001);
    model[5] = 32'h0BAD_F00D;
    issue(2'b01, 4'd5, 32'h0);

    // Random mix (R2, R5, R7 tag wrap, R8, R9, R10)
    for (int n = 0; n < 80; n++) begin
      logic [1:0] op;
      op = 2'(1 + ($urandom % 3));
      w  = $urandom;
      issue(op, 4'($urandom % 16), w);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule